// File: doc/BRIEF.md
# Multithreaded Micro-op Dispatch Queue

This block sits between instruction fetch and decode in a core that runs several hardware threads. Fetch hands it micro-ops, which are opaque data words, through one enqueue port per thread. Each thread has its own FIFO, so a thread whose decode path is stalled never holds back the others. In every cycle the block offers up to `DEC_W` micro-ops to decode on a bundle of slots. Slots are filled from slot 0 upward. Threads take turns, one entry per turn, and the first turn of each cycle goes to a pseudo-randomly chosen active thread.

Each thread queue tracks its fill level with a small state machine. The states are `QS_EMPTY`, `QS_PARTIAL` and `QS_FULL`. The transitions are:

- FILL: `QS_EMPTY` to `QS_PARTIAL`, or to `QS_FULL`, on a push.
- DRAIN: `QS_PARTIAL` or `QS_FULL` to `QS_EMPTY` when the count reaches zero.
- TOPUP: `QS_PARTIAL` to `QS_FULL` when the count reaches the depth.
- RELEASE: `QS_FULL` to `QS_PARTIAL` when entries leave.
- FLUSH: any state to `QS_EMPTY` on a squash.

The slot bundle is combinational on the registered queue contents. A micro-op shown in slot s during a cycle leaves its queue at the next rising edge. Other threads' squash and stall inputs also act on that same cycle.

Top module: `mtfq_dispatch`

## Requirements
- R1: Each thread has an independent queue of `DEPTH` entries. Micro-ops of one thread reach decode in the order they were accepted.
- R2: `enq_rdy[t]` is low while thread t's queue holds `DEPTH` entries. An enqueue attempted while `enq_rdy[t]` is low is dropped.
- R3: At most `FETCH_W` enqueues are accepted per cycle. Candidates are granted by ascending thread index, and a candidate is any thread with `enq_vld` high whose queue is not full. A thread beyond the limit sees `enq_rdy` low.
- R4: At most `DEC_W` slots are valid per cycle. Valid slots are contiguous from slot 0, and `dec_cnt` equals the number of valid slots.
- R5: The first thread of each cycle is the k-th active thread in ascending index order, counting from k = 0. Here k is the LFSR value modulo the number of active threads. The LFSR is 16 bits wide with seed 0xACE1. Each cycle after reset it shifts left and takes bit 15 ^ bit 13 ^ bit 12 ^ bit 10 into bit 0.
- R6: After each slot is filled, the search resumes at the next thread index, wrapping from the highest index to 0. The first eligible thread found supplies the next slot, one entry per turn. `dec_tid[s]` names the thread of slot s.
- R7: A thread is skipped when it is inactive, stalled, squashed, or has no entries left to offer. With no active thread no slot is valid.
- R8: `squash[t]` empties thread t's queue at the next edge, and none of its entries is dispatched in that cycle. A push to t in that same cycle is dropped. Every other queue is untouched.
- R9: `drained` is high exactly when every queue is empty.
- R10: `activity` is high exactly when at least one slot is valid.
- R11: Reset empties all queues and loads the LFSR seed.
- R12: A micro-op accepted at an edge can appear in a slot during the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_vld | input | N | Per-thread enqueue request |
| enq_data | input | N x DW | Per-thread micro-op word |
| enq_rdy | output | N | Per-thread credit: a push is accepted this cycle |
| dec_stall | input | N | Per-thread decode stall |
| squash | input | N | Per-thread queue flush |
| thr_active | input | N | Threads eligible for dispatch |
| dec_vld | output | DEC_W | Slot valid bits |
| dec_data | output | DEC_W x DW | Slot micro-op words |
| dec_tid | output | DEC_W x TID_W | Slot thread index |
| dec_cnt | output | clog2(DEC_W+1) | Number of valid slots |
| activity | output | 1 | At least one slot valid |
| drained | output | 1 | All queues empty |

## Verification
The hardest situation to reach is a full dispatch cycle where several threads with different fill levels compete for the slots. In that cycle some threads run dry partway through the cycle, the search has to wrap, and the LFSR start point lands on each active thread in turn. The directed tests reach it by filling queues under stall and then releasing all threads at once. A long mixed phase then drives varying pushes, stalls, squashes and active masks. Throughout, a bench model predicts every slot. It tracks the LFSR from reset, so each start thread and interleaving order is checked exactly.

// File: rtl/mtfq_pkg.sv
package mtfq_pkg;

    typedef enum logic [1:0] {
        QS_EMPTY   = 2'd0,
        QS_PARTIAL = 2'd1,
        QS_FULL    = 2'd2
    } qstate_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/mtfq_lfsr.sv
module mtfq_lfsr #(
    parameter logic [15:0] SEED = mtfq_pkg::LFSR_SEED
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);

    logic feedback;

    assign feedback = value[15] ^ value[13] ^ value[12] ^ value[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= SEED;
        end else begin
            value <= {value[14:0], feedback};
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        value != 16'd0); // R5

endmodule

// File: rtl/mtfq_thread_queue.sv
module mtfq_thread_queue
    import mtfq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int PEEK  = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int OW   = $clog2(PEEK + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [DW-1:0]             push_data,
    input  logic [OW-1:0]             pop_cnt,
    output logic [PEEK-1:0][DW-1:0]   peek_data,
    output logic [CW-1:0]             count,
    output logic                      is_empty,
    output logic                      is_full
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    qstate_e       state_q;
    qstate_e       state_d;

    assign cnt_nxt = cnt_q + CW'(push) - CW'(pop_cnt);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = QS_EMPTY;
        end else begin
            unique case (state_q)
                QS_EMPTY: begin
                    if (push) begin
                        state_d = (cnt_nxt == CW'(DEPTH)) ? QS_FULL : QS_PARTIAL;
                    end
                end
                QS_PARTIAL: begin
                    if (cnt_nxt == '0) begin
                        state_d = QS_EMPTY;
                    end else if (cnt_nxt == CW'(DEPTH)) begin
                        state_d = QS_FULL;
                    end
                end
                QS_FULL: begin
                    if (cnt_nxt != CW'(DEPTH)) begin
                        state_d = (cnt_nxt == '0) ? QS_EMPTY : QS_PARTIAL;
                    end
                end
                default: state_d = QS_EMPTY;
            endcase
        end
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_EMPTY;
            cnt_q   <= '0;
            rd_ptr  <= '0;
            wr_ptr  <= '0;
        end else if (flush) begin
            state_q <= QS_EMPTY;
            cnt_q   <= '0;
            rd_ptr  <= '0;
            wr_ptr  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_nxt;
            rd_ptr  <= rd_ptr + PW'(pop_cnt);
            wr_ptr  <= wr_ptr + PW'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // outputs
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state_q)
            QS_EMPTY:   is_empty = 1'b1;
            QS_PARTIAL: ;
            QS_FULL:    is_full  = 1'b1;
            default:    is_empty = 1'b1;
        endcase
        count = cnt_q;
        for (int i = 0; i < PEEK; i++) begin
            peek_data[i] = mem[rd_ptr + PW'(i)];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (state_q != QS_FULL)); // R2
    AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_cnt) <= int'(cnt_q)); // R1
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> is_empty); // R8
    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_EMPTY) == (cnt_q == '0)); // R9

endmodule

// File: rtl/mtfq_dispatch_arb.sv
module mtfq_dispatch_arb #(
    parameter int N      = 4,
    parameter int DEC_W  = 4,
    parameter int CW     = 6,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1,
    localparam int OW    = $clog2(DEC_W + 1)
) (
    input  logic [N-1:0]                  active,
    input  logic [N-1:0]                  elig,
    input  logic [CW-1:0]                 cnt [N],
    input  logic [15:0]                   lfsr,
    output logic [DEC_W-1:0]              slot_vld,
    output logic [DEC_W-1:0][TID_W-1:0]   slot_tid,
    output logic [DEC_W-1:0][OW-1:0]      slot_off,
    output logic [OW-1:0]                 slot_num,
    output logic [OW-1:0]                 pop_cnt [N]
);

    int          nact_i;
    int          k_i;
    int          seen_i;
    int          start_i;
    int          cur_i;
    int          pick_i;
    int          idx_i;
    logic [OW-1:0] taken [N];

    always_comb begin
        nact_i = 0;
        for (int t = 0; t < N; t++) begin
            if (active[t]) nact_i = nact_i + 1;
        end
        k_i = (nact_i == 0) ? 0 : (int'(lfsr) % nact_i);
        // locate k-th active thread
        start_i = 0;
        seen_i  = 0;
        for (int t = 0; t < N; t++) begin
            if (active[t]) begin
                if (seen_i == k_i) start_i = t;
                seen_i = seen_i + 1;
            end
        end
        for (int t = 0; t < N; t++) begin
            taken[t] = '0;
        end
        cur_i    = start_i;
        slot_num = '0;
        idx_i    = 0;
        for (int s = 0; s < DEC_W; s++) begin
            slot_vld[s] = 1'b0;
            slot_tid[s] = '0;
            slot_off[s] = '0;
            pick_i = -1;
            for (int j = 0; j < N; j++) begin
                idx_i = cur_i + j;
                if (idx_i >= N) idx_i = idx_i - N;
                if (pick_i < 0 && elig[idx_i] &&
                    int'(taken[idx_i]) < int'(cnt[idx_i])) begin
                    pick_i = idx_i;
                end
            end
            if (pick_i >= 0) begin
                slot_vld[s]     = 1'b1;
                slot_tid[s]     = TID_W'(pick_i);
                slot_off[s]     = taken[pick_i];
                taken[pick_i]   = taken[pick_i] + OW'(1);
                slot_num        = slot_num + OW'(1);
                cur_i           = pick_i + 1;
                if (cur_i >= N) cur_i = 0;
            end
        end
        for (int t = 0; t < N; t++) begin
            pop_cnt[t] = taken[t];
        end
    end

endmodule

// File: rtl/mtfq_dispatch.sv
module mtfq_dispatch
    import mtfq_pkg::*;
#(
    parameter int N       = 4,
    parameter int DW      = 32,
    parameter int DEPTH   = 32,
    parameter int DEC_W   = 4,
    parameter int FETCH_W = 8,
    localparam int TID_W  = (N > 1) ? $clog2(N) : 1,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int OW     = $clog2(DEC_W + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  enq_vld,
    input  logic [N-1:0][DW-1:0]          enq_data,
    output logic [N-1:0]                  enq_rdy,
    input  logic [N-1:0]                  dec_stall,
    input  logic [N-1:0]                  squash,
    input  logic [N-1:0]                  thr_active,
    output logic [DEC_W-1:0]              dec_vld,
    output logic [DEC_W-1:0][DW-1:0]      dec_data,
    output logic [DEC_W-1:0][TID_W-1:0]   dec_tid,
    output logic [OW-1:0]                 dec_cnt,
    output logic                          activity,
    output logic                          drained
);

    logic [15:0]                  lfsr_val;
    logic [N-1:0]                 q_full;
    logic [N-1:0]                 q_empty;
    logic [N-1:0]                 q_push;
    logic [N-1:0]                 q_elig;
    logic [CW-1:0]                q_cnt  [N];
    logic [OW-1:0]                q_pop  [N];
    logic [DEC_W-1:0][DW-1:0]     q_peek [N];
    logic [DEC_W-1:0][OW-1:0]     slot_off;
    int                           grant_i;

    mtfq_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (lfsr_val)
    );

    // enqueue credit with per-cycle fetch limit
    always_comb begin
        grant_i = 0;
        for (int t = 0; t < N; t++) begin
            enq_rdy[t] = !q_full[t] && (grant_i < FETCH_W);
            if (enq_vld[t] && !q_full[t]) grant_i = grant_i + 1;
            q_push[t] = enq_vld[t] && enq_rdy[t] && !squash[t];
            q_elig[t] = thr_active[t] && !dec_stall[t] && !squash[t];
        end
    end

    for (genvar t = 0; t < N; t++) begin : g_q
        mtfq_thread_queue #(
            .DW    (DW),
            .DEPTH (DEPTH),
            .PEEK  (DEC_W)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (squash[t]),
            .push      (q_push[t]),
            .push_data (enq_data[t]),
            .pop_cnt   (q_pop[t]),
            .peek_data (q_peek[t]),
            .count     (q_cnt[t]),
            .is_empty  (q_empty[t]),
            .is_full   (q_full[t])
        );
    end

    mtfq_dispatch_arb #(
        .N     (N),
        .DEC_W (DEC_W),
        .CW    (CW)
    ) u_arb (
        .active   (thr_active),
        .elig     (q_elig),
        .cnt      (q_cnt),
        .lfsr     (lfsr_val),
        .slot_vld (dec_vld),
        .slot_tid (dec_tid),
        .slot_off (slot_off),
        .slot_num (dec_cnt),
        .pop_cnt  (q_pop)
    );

    // slot data steering
    always_comb begin
        for (int s = 0; s < DEC_W; s++) begin
            dec_data[s] = '0;
            for (int t = 0; t < N; t++) begin
                for (int o = 0; o < DEC_W; o++) begin
                    if (dec_vld[s] && dec_tid[s] == TID_W'(t) &&
                        slot_off[s] == OW'(o)) begin
                        dec_data[s] = q_peek[t][o];
                    end
                end
            end
        end
    end

    assign activity = |dec_vld;
    assign drained  = &q_empty;

    AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_push) <= FETCH_W); // R3
    AST_SLOTS_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_vld + DEC_W'(1)) & dec_vld) == '0); // R4
    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dec_cnt) == $countones(dec_vld)); // R4
    AST_DRAINED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (dec_cnt == '0)); // R9
    AST_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        activity == (dec_cnt != '0)); // R10

    for (genvar s = 0; s < DEC_W; s++) begin : g_slot_chk
        AST_STALL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            dec_vld[s] |-> (thr_active[dec_tid[s]] && !dec_stall[dec_tid[s]])); // R7
        AST_SQUASH_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
            dec_vld[s] |-> !squash[dec_tid[s]]); // R8
    end

endmodule

// File: tb/mtfq_dispatch_tb_top.sv
`timescale 1ns/1ps
module mtfq_dispatch_tb_top;

    localparam int N   = 4;
    localparam int DW  = 16;
    localparam int D   = 8;
    localparam int DEC = 4;
    localparam int FW  = 2;
    localparam int TW  = 2;
    localparam int SW  = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [N-1:0]              enq_vld = '0;
    logic [N-1:0][DW-1:0]      enq_data = '0;
    logic [N-1:0]              enq_rdy;
    logic [N-1:0]              dec_stall = '0;
    logic [N-1:0]              squash = '0;
    logic [N-1:0]              thr_active = '0;
    logic [DEC-1:0]            dec_vld;
    logic [DEC-1:0][DW-1:0]    dec_data;
    logic [DEC-1:0][TW-1:0]    dec_tid;
    logic [SW-1:0]             dec_cnt;
    logic                      activity;
    logic                      drained;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // reference model
    logic [DW-1:0] m_mem [N][D];
    int            m_head [N];
    int            m_cnt  [N];
    logic [15:0]   m_lfsr;
    logic [N-1:0]  e_rdy;
    logic [N-1:0]  e_push;
    int            e_pop [N];
    logic [DEC-1:0] e_vld;
    logic [DW-1:0] e_data [DEC];
    int            e_tid  [DEC];
    int            e_cnt;
    logic [31:0]   rs = 32'h1234_5678;
    int            seqn = 0;

    always #2.5 clk = ~clk;

    mtfq_dispatch #(
        .N(N), .DW(DW), .DEPTH(D), .DEC_W(DEC), .FETCH_W(FW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .enq_data(enq_data),
        .enq_rdy(enq_rdy), .dec_stall(dec_stall), .squash(squash),
        .thr_active(thr_active), .dec_vld(dec_vld), .dec_data(dec_data),
        .dec_tid(dec_tid), .dec_cnt(dec_cnt), .activity(activity),
        .drained(drained)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic compute_exp();
        int g, nact, k, seen, start, cur, pick, idx;
        int taken [N];
        g = 0;
        for (int t = 0; t < N; t++) begin
            e_rdy[t]  = (m_cnt[t] < D) && (g < FW);
            if (enq_vld[t] && m_cnt[t] < D) g++;
            e_push[t] = enq_vld[t] && e_rdy[t] && !squash[t];
            taken[t]  = 0;
        end
        nact = 0;
        for (int t = 0; t < N; t++) if (thr_active[t]) nact++;
        k = (nact == 0) ? 0 : int'(m_lfsr) % nact;
        start = 0; seen = 0;
        for (int t = 0; t < N; t++) begin
            if (thr_active[t]) begin
                if (seen == k) start = t;
                seen++;
            end
        end
        cur = start; e_cnt = 0;
        for (int s = 0; s < DEC; s++) begin
            e_vld[s] = 1'b0; e_data[s] = '0; e_tid[s] = 0;
            pick = -1;
            for (int j = 0; j < N; j++) begin
                idx = (cur + j) % N;
                if (pick < 0 && thr_active[idx] && !dec_stall[idx] && !squash[idx]
                    && taken[idx] < m_cnt[idx]) pick = idx;
            end
            if (pick >= 0) begin
                e_vld[s]  = 1'b1;
                e_tid[s]  = pick;
                e_data[s] = m_mem[pick][(m_head[pick] + taken[pick]) % D];
                taken[pick]++;
                e_cnt++;
                cur = (pick + 1) % N;
            end
        end
        for (int t = 0; t < N; t++) e_pop[t] = taken[t];
    endtask

    // one cycle: compare at mid-cycle, then advance model at the edge
    task automatic step();
        logic dr;
        #1;
        compute_exp();
        dr = 1'b1;
        for (int t = 0; t < N; t++) if (m_cnt[t] != 0) dr = 1'b0;
        chk("R2/R3", "enq_rdy", 32'(enq_rdy), 32'(e_rdy));
        chk("R4", "dec_cnt", 32'(dec_cnt), 32'(e_cnt));
        chk("R9", "drained", 32'(drained), 32'(dr));
        chk("R10", "activity", 32'(activity), 32'(e_cnt > 0));
        for (int s = 0; s < DEC; s++) begin
            chk("R4/R7", "slot valid", 32'(dec_vld[s]), 32'(e_vld[s]));
            if (e_vld[s]) begin
                chk("R5/R6", "slot tid", 32'(dec_tid[s]), 32'(e_tid[s]));
                chk("R1/R6", "slot data", 32'(dec_data[s]), 32'(e_data[s]));
            end
        end
        @(posedge clk);
        for (int t = 0; t < N; t++) begin
            if (squash[t]) begin
                m_cnt[t] = 0; m_head[t] = 0;
            end else begin
                if (e_push[t]) m_mem[t][(m_head[t] + m_cnt[t]) % D] = enq_data[t];
                m_head[t] = (m_head[t] + e_pop[t]) % D;
                m_cnt[t]  = m_cnt[t] - e_pop[t] + (e_push[t] ? 1 : 0);
            end
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        enq_vld = '0; squash = '0; dec_stall = '0;
    endtask

    function automatic logic [DW-1:0] tag_word(input int t);
        seqn++;
        return DW'((t << 12) | (seqn & 12'hFFF));
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; clear_inputs(); thr_active = '0;
        repeat (3) @(negedge clk);
        for (int t = 0; t < N; t++) begin m_cnt[t] = 0; m_head[t] = 0; end
        m_lfsr = 16'hACE1;
        rst_n = 1'b1; thr_active = '1;
        #1;
        chk("R11", "drained after reset", 32'(drained), 32'd1);
        chk("R11", "no slots after reset", 32'(dec_cnt), 32'd0);
        chk("R11", "credit after reset", 32'(enq_rdy), 32'hF);
        step();
    endtask

    task automatic t_fifo_order();
        logic [DW-1:0] w [3];
        thr_active = 4'b0010; dec_stall = 4'b0010;
        for (int i = 0; i < 3; i++) begin
            w[i] = tag_word(1);
            enq_vld = 4'b0010; enq_data[1] = w[i];
            step();
        end
        enq_vld = '0; dec_stall = '0;
        #1;
        chk("R1", "count single thread", 32'(dec_cnt), 32'd3);
        for (int i = 0; i < 3; i++) chk("R1", "fifo order", 32'(dec_data[i]), 32'(w[i]));
        step();
        #1;
        chk("R12", "drained after dispatch", 32'(drained), 32'd1);
        step();
    endtask

    task automatic t_same_cycle();
        thr_active = 4'b0100;
        enq_vld = 4'b0100; enq_data[2] = tag_word(2);
        step();
        enq_vld = '0;
        #1;
        chk("R12", "next-cycle dispatch", 32'(dec_cnt), 32'd1);
        step();
    endtask

    task automatic t_interleave();
        dec_stall = '1; thr_active = '1;
        for (int i = 0; i < 3; i++) begin
            enq_vld = 4'b0001; enq_data[0] = tag_word(0); step();
        end
        for (int i = 0; i < 2; i++) begin
            enq_vld = 4'b0100; enq_data[2] = tag_word(2); step();
        end
        enq_vld = 4'b1000; enq_data[3] = tag_word(3); step();
        enq_vld = '0; dec_stall = '0;
        #1;
        chk("R6", "interleave fills width", 32'(dec_cnt), 32'd4);
        for (int s = 1; s < DEC; s++)
            chk("R6", "adjacent slots differ", 32'(dec_tid[s] != dec_tid[s-1]), 32'd1);
        for (int i = 0; i < 4; i++) step();
    endtask

    task automatic t_stall();
        dec_stall = '1; thr_active = '1;
        enq_vld = 4'b0011; enq_data[0] = tag_word(0); enq_data[1] = tag_word(1);
        step();
        enq_vld = '0; dec_stall = 4'b0001;
        #1;
        for (int s = 0; s < DEC; s++)
            if (dec_vld[s]) chk("R7", "stalled thread skipped", 32'(dec_tid[s]), 32'd1);
        step();
        dec_stall = '0;
        step(); step();
    endtask

    task automatic t_squash();
        dec_stall = '1; thr_active = '1;
        for (int i = 0; i < 2; i++) begin
            enq_vld = 4'b0110; enq_data[1] = tag_word(1); enq_data[2] = tag_word(2);
            step();
        end
        squash = 4'b0010; enq_vld = 4'b0010; enq_data[1] = tag_word(1); dec_stall = '0;
        #1;
        for (int s = 0; s < DEC; s++)
            if (dec_vld[s]) chk("R8", "squashed thread hidden", 32'(dec_tid[s]), 32'd2);
        step();
        squash = '0; enq_vld = '0; dec_stall = 4'b0100;
        #1;
        chk("R8", "squash wins over push", 32'(dec_cnt), 32'd0);
        step();
        dec_stall = '0;
        step();
    endtask

    task automatic t_full();
        thr_active = '1; dec_stall = 4'b1000;
        for (int i = 0; i < D; i++) begin
            enq_vld = 4'b1000; enq_data[3] = tag_word(3); step();
        end
        enq_vld = 4'b1000; enq_data[3] = 16'hDEAD;
        #1;
        chk("R2", "credit low when full", 32'(enq_rdy[3]), 32'd0);
        step();
        enq_vld = '0; dec_stall = '0;
        for (int i = 0; i < 3; i++) step();
        #1;
        chk("R2", "dropped push never appears", 32'(drained), 32'd1);
        step();
    endtask

    task automatic t_fetch_width();
        thr_active = '1; dec_stall = '1;
        enq_vld = '1;
        for (int t = 0; t < N; t++) enq_data[t] = tag_word(t);
        #1;
        chk("R3", "fetch width grant", 32'(enq_rdy), 32'h3);
        step();
        enq_vld = '0;
        step();
    endtask

    task automatic t_no_active();
        thr_active = '0; dec_stall = '0;
        #1;
        chk("R7", "no active no slots", 32'(dec_cnt), 32'd0);
        chk("R9", "not drained with entries", 32'(drained), 32'd0);
        step();
        thr_active = 4'b0010;
        step();
        thr_active = '1;
        step(); step();
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 400; i++) begin
            rs = rs * 32'd1664525 + 32'd1013904223;
            enq_vld    = rs[7:4];
            dec_stall  = rs[11:8] & rs[15:12];
            squash     = (rs[23:20] == 4'd0) ? rs[27:24] : 4'd0;
            thr_active = (rs[31:28] == 4'd0) ? 4'd0 : (rs[19:16] | 4'b0001) ;
            for (int t = 0; t < N; t++) enq_data[t] = tag_word(t);
            step();
        end
        clear_inputs(); thr_active = '1;
        for (int i = 0; i < 12; i++) step();
        #1;
        chk("R9", "drained at end", 32'(drained), 32'd1);
    endtask

    initial begin
        t_reset();
        t_fifo_order();
        t_same_cycle();
        t_interleave();
        t_stall();
        t_squash();
        t_full();
        t_fetch_width();
        t_no_active();
        t_reset();
        t_mixed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule